// File: doc/BRIEF.md
# Indexed Effective-Address Sequencer with Page-Cross Fixup

This block forms an effective address from a 16-bit base and an 8-bit unsigned index while owning only an adder as wide as the index. When a start strobe arrives, the low byte of the base is summed with the index. The result drives the bus in the very next cycle. The high byte is not touched in that step.

If the low-byte sum carries, one extra bus cycle is spent. In that cycle a dummy read goes out on the partly formed address, which is the old high byte with the new low byte. During the same cycle the high byte is incremented, and the real access follows. A write always spends this extra cycle, even with no carry, so a store can never land on an unfinished address.

The bus may stretch any cycle by holding a ready input low. A done pulse marks the real access. The effective address and a count of the bus cycles used stay on the outputs until the next start.

Top module: `ea_page_seq`

## Requirements
- R1: After reset, and in any cycle with no sequence in progress, `bus_valid` and `done` are 0, `bus_addr` is 0 and the sequencer accepts a new start; after reset `eff_addr` and `cyc_count` read 0.
- R2: A read (`wr`=0) whose low-byte sum does not carry drives exactly one bus cycle, in the cycle after start: `bus_addr` = base+index, `bus_we`=0, `bus_dummy`=0.
- R3: A read whose low-byte sum carries first drives a dummy read (`bus_dummy`=1, `bus_we`=0) at {base[15:8], base[7:0]+index}, then a real read at base+index with the same low byte and a high byte one greater.
- R4: A write (`wr`=1) always drives a dummy read at {base[15:8], base[7:0]+index} first, then a write (`bus_we`=1, `bus_dummy`=0) at base+index, whether or not the low byte carried.
- R5: Addresses wrap modulo 2^16: a high byte of 0xFF that takes the carry becomes 0x00, and the dummy cycle still occurs.
- R6: While `bus_valid`=1 and `bus_ready`=0, the bus cycle is stretched: `bus_addr`, `bus_we` and `bus_dummy` hold and the sequence does not advance.
- R7: `done` is high for exactly the one cycle in which the real (non-dummy) access is accepted (`bus_valid` and `bus_ready` both 1).
- R8: `eff_addr` equals (base+index) mod 2^16 in the real-access cycle and holds that value until the next accepted start.
- R9: `cyc_count` counts the bus cycles accepted since the last start. It ends at 1 for a read without carry and at 2 for any write or carrying read, and holds until the next start.
- R10: A start strobe that arrives while a sequence is in progress (`bus_valid`=1) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a new address sequence (sampled when idle) |
| base | input | 16 | Base address |
| index | input | 8 | Unsigned index |
| wr | input | 1 | 1 = the operation is a write, 0 = read |
| bus_ready | input | 1 | Bus accepts the current cycle |
| bus_valid | output | 1 | A bus cycle is being driven |
| bus_addr | output | 16 | Address of the current bus cycle |
| bus_we | output | 1 | Current bus cycle is a write |
| bus_dummy | output | 1 | Current bus cycle is a dummy read |
| eff_addr | output | 16 | Effective address (final from the done cycle) |
| done | output | 1 | One-cycle pulse with the real access |
| cyc_count | output | 2 | Bus cycles accepted in this sequence |

## Verification
The first bus cycle shows up one clock after the edge that samples start. A dummy cycle pushes the real access back by one more accepted cycle. Each stretched cycle adds one clock more. `done` depends combinationally on `bus_ready` in the real-access cycle, and `cyc_count` rises on the edge that accepts each cycle. The bench drives its inputs just after the falling edge and lets them settle. It then compares every output against a queue of expected bus cycles. The queue advances only when the bench itself raised ready, so the checks follow each result to its exact cycle, even through stalls.

// File: rtl/ea_pkg.sv
// Package: shared state type for the effective-address sequencer.
// Assumes: three states are enough (idle, fixup dummy cycle, real access).
package ea_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIX  = 2'd1,
        ST_REAL = 2'd2
    } ea_state_e;

endpackage

// File: rtl/ea_lowadd.sv
// Module: ea_lowadd
// Adds the index to the low part of the base in one step and returns the
// sum and the carry out of the top bit. Purely combinational.
// Assumes: both operands have the same width W (the page width).
module ea_lowadd #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);

    // Single W-bit addition with carry out.
    always_comb begin
        {cout, sum} = {1'b0, a} + {1'b0, b};
    end

endmodule

// File: rtl/ea_hiinc.sv
// Module: ea_hiinc
// Applies a pending carry to the high part of the address. Wraps around
// at the top of the address space, so an all-ones high part goes to zero.
// Assumes: carry is one bit and only ever increments (unsigned index).
module ea_hiinc #(
    parameter int W = 8
) (
    input  logic [W-1:0] hi_in,
    input  logic         inc,
    output logic [W-1:0] hi_out
);

    // Increment modulo 2^W.
    always_comb begin
        hi_out = hi_in + {{(W-1){1'b0}}, inc};
    end

endmodule

// File: rtl/ea_seq_ctl.sv
// Module: ea_seq_ctl
// State machine for one address sequence: idle, optional fixup (dummy read)
// cycle, then the real access. It advances out of a bus state only when the
// bus accepts the cycle.
// Assumes: carry_now is the carry of the low-part sum of the inputs that are
// present in the same cycle as start.
module ea_seq_ctl
    import ea_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      wr,
    input  logic      carry_now,
    input  logic      ready,
    output ea_state_e state,
    output logic      load,
    output logic      fix_step,
    output logic      fin
);

    ea_state_e state_q;
    ea_state_e state_d;

    // Step strobes, decoded from the current state and the bus handshake.
    always_comb begin
        load     = (state_q == ST_IDLE) && start;
        fix_step = (state_q == ST_FIX)  && ready;
        fin      = (state_q == ST_REAL) && ready;
    end

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)    state_d = (carry_now || wr) ? ST_FIX : ST_REAL;
            ST_FIX:  if (ready)    state_d = ST_REAL;
            ST_REAL: if (ready)    state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;

endmodule

// File: rtl/ea_page_seq.sv
// Module: ea_page_seq (top)
// Forms base+index with an adder only as wide as the index. The low part is
// summed when start is taken. A carry, or any write, inserts a fixup cycle
// that reads the half-formed address while the high part is incremented. The
// real access follows. Counts the accepted bus cycles of the sequence.
// Assumes: unsigned index; synchronous active-low reset; the bus stretches a
// cycle by holding bus_ready low.
module ea_page_seq
    import ea_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  index,
    input  logic              wr,
    input  logic              bus_ready,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_dummy,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              done,
    output logic [CNT_W-1:0]  cyc_count
);

    localparam int HI_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] lo_sum;
    logic             lo_carry;
    logic [HI_W-1:0]  hi_next;
    logic [IDX_W-1:0] lo_q;
    logic [HI_W-1:0]  hi_q;
    logic             carry_q;
    logic             wr_q;
    logic [CNT_W-1:0] cnt_q;
    ea_state_e        state;
    logic             load;
    logic             fix_step;
    logic             fin;

    ea_lowadd #(.W(IDX_W)) u_lowadd (
        .a    (base[IDX_W-1:0]),
        .b    (index),
        .sum  (lo_sum),
        .cout (lo_carry)
    );

    ea_hiinc #(.W(HI_W)) u_hiinc (
        .hi_in  (hi_q),
        .inc    (carry_q),
        .hi_out (hi_next)
    );

    ea_seq_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .wr        (wr),
        .carry_now (lo_carry),
        .ready     (bus_ready),
        .state     (state),
        .load      (load),
        .fix_step  (fix_step),
        .fin       (fin)
    );

    // Address halves, pending carry and direction, captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            carry_q <= 1'b0;
            wr_q    <= 1'b0;
        end else if (load) begin
            lo_q    <= lo_sum;
            hi_q    <= base[ADDR_W-1:IDX_W];
            carry_q <= lo_carry;
            wr_q    <= wr;
        end else if (fix_step) begin
            hi_q    <= hi_next;
            carry_q <= 1'b0;
        end
    end

    // Accepted-cycle counter, cleared by a new start.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load)              cnt_q <= '0;
        else if (fix_step || fin)   cnt_q <= cnt_q + 1'b1;
    end

    // Bus-side outputs decoded from the state and captured address.
    always_comb begin
        bus_valid = (state != ST_IDLE);
        bus_addr  = bus_valid ? {hi_q, lo_q} : '0;
        bus_we    = (state == ST_REAL) && wr_q;
        bus_dummy = (state == ST_FIX);
        done      = fin;
        eff_addr  = {hi_q, lo_q};
        cyc_count = cnt_q;
    end

endmodule

// File: rtl/ea_page_seq_chk.sv
// Module: ea_page_seq_chk
// Property checker attached to every ea_page_seq instance via bind.
// Assumes: the IDX_W low address bits form the page offset.
module ea_page_seq_chk #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 8,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              bus_ready,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic              bus_dummy,
    input logic [ADDR_W-1:0] eff_addr,
    input logic              done,
    input logic [CNT_W-1:0]  cyc_count
);

    // R1: the cycle after a reset edge has no bus activity
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !bus_valid && !done);

    // R3, R4: the dummy cycle is never a write
    a_r4_dummy_is_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dummy |-> bus_valid && !bus_we);

    // R3: an accepted dummy cycle is followed by the real access on the same low byte
    a_r3_fix_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dummy && bus_ready |=> bus_valid && !bus_dummy &&
            (bus_addr[IDX_W-1:0] == $past(bus_addr[IDX_W-1:0])));

    // R6: a stretched cycle holds its address and kind
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) &&
            $stable(bus_we) && $stable(bus_dummy));

    // R7: done comes with an accepted real access and lasts one cycle
    a_r7_done_with_access: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_valid && bus_ready && !bus_dummy);
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: while idle without a start, the effective address holds
    a_r8_eff_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid && !start |=> $stable(eff_addr));

    // R9: never more than two bus cycles per sequence
    a_r9_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_count <= 2);

endmodule

bind ea_page_seq ea_page_seq_chk #(
    .ADDR_W(ADDR_W),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_ready (bus_ready),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_dummy (bus_dummy),
    .eff_addr  (eff_addr),
    .done      (done),
    .cyc_count (cyc_count)
);

// File: tb/ea_page_seq_test.sv
// Bench for ea_page_seq: a queue of expected bus cycles is the reference
// model; every clock the design's outputs are compared against its head.
module ea_page_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base = '0;
    logic [7:0]  index = '0;
    logic        wr = 1'b0;
    logic        bus_ready = 1'b1;
    logic        bus_valid;
    logic [15:0] bus_addr;
    logic        bus_we;
    logic        bus_dummy;
    logic [15:0] eff_addr;
    logic        done;
    logic [1:0]  cyc_count;

    int n_checks = 0;
    int n_fail   = 0;
    int n_cycles = 0;
    string stag = "R1";

    // reference model state
    logic [15:0] q_addr[$];
    bit          q_we[$];
    bit          q_dum[$];
    bit          q_fin[$];
    int          m_cnt = 0;
    logic [15:0] m_eff = '0;
    bit          seen_reset = 0;

    always #2 clk = ~clk;   // 250 MHz

    ea_page_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .index(index),
        .wr(wr), .bus_ready(bus_ready), .bus_valid(bus_valid),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_dummy(bus_dummy),
        .eff_addr(eff_addr), .done(done), .cyc_count(cyc_count)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        n_cycles++;
        if (n_cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", n_cycles, 20000);
            finish_run();
        end
    end

    // Compare outputs with the model, then advance the model for the coming edge.
    task automatic compare_and_advance();
        bit busy;
        logic [15:0] part, full;
        logic [8:0]  lsum;
        if (rst_n && seen_reset) begin
            if (q_addr.size() > 0) begin
                check(bus_valid === 1'b1, stag, "bus_valid", bus_valid, 1);
                check(bus_addr === q_addr[0], stag, "bus_addr", bus_addr, q_addr[0]);
                check(bus_we === q_we[0], stag, "bus_we", bus_we, q_we[0]);
                check(bus_dummy === q_dum[0], stag, "bus_dummy", bus_dummy, q_dum[0]);
                check(done === (q_fin[0] && bus_ready), "R7", "done", done, q_fin[0] && bus_ready);
                if (q_fin[0]) check(eff_addr === m_eff, "R8", "eff_addr", eff_addr, m_eff);
            end else begin
                check(bus_valid === 1'b0, "R1", "bus_valid idle", bus_valid, 0);
                check(bus_addr === 16'h0, "R1", "bus_addr idle", bus_addr, 0);
                check(done === 1'b0, "R7", "done idle", done, 0);
                check(eff_addr === m_eff, "R8", "eff_addr idle", eff_addr, m_eff);
            end
            check(cyc_count === 2'(m_cnt), "R9", "cyc_count", cyc_count, m_cnt);
        end
        if (!rst_n) begin
            q_addr.delete(); q_we.delete(); q_dum.delete(); q_fin.delete();
            m_cnt = 0; m_eff = '0; seen_reset = 1;
            return;
        end
        busy = (q_addr.size() > 0);
        if (busy) begin
            if (bus_ready) begin
                void'(q_addr.pop_front()); void'(q_we.pop_front());
                void'(q_dum.pop_front()); void'(q_fin.pop_front());
                m_cnt++;
            end
        end else if (start) begin
            lsum = {1'b0, base[7:0]} + {1'b0, index};
            part = {base[15:8], lsum[7:0]};
            full = base + {8'h00, index};
            m_cnt = 0;
            m_eff = full;
            if (lsum[8] || wr) begin
                q_addr.push_back(part); q_we.push_back(0); q_dum.push_back(1); q_fin.push_back(0);
            end
            q_addr.push_back(full); q_we.push_back(wr); q_dum.push_back(0); q_fin.push_back(1);
        end
    endtask

    // One clock: drive inputs after the falling edge, settle, compare.
    task automatic step(input bit s, input logic [15:0] b, input logic [7:0] i,
                        input bit w, input bit r);
        @(negedge clk);
        start = s; base = b; index = i; wr = w; bus_ready = r;
        #1;
        compare_and_advance();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 16'h0, 8'h0, 0, 1);
    endtask

    task automatic op(input string tag, input logic [15:0] b, input logic [7:0] i, input bit w);
        stag = tag;
        step(1, b, i, w, 1);
        idle(4);
    endtask

    initial begin
        rst_n = 1'b0;
        step(0, 16'h0, 8'h0, 0, 1);
        step(0, 16'h0, 8'h0, 0, 1);
        rst_n = 1'b1;
        stag = "R1";
        idle(3);

        op("R2", 16'h0280, 8'h7F, 0);   // 02FF, single cycle
        op("R2", 16'h4000, 8'h00, 0);
        op("R3", 16'h0280, 8'h80, 0);   // dummy 0200 then 0300
        op("R3", 16'h80F0, 8'h50, 0);   // dummy 8040 then 8140
        op("R4", 16'h1234, 8'h10, 1);   // dummy 1244 then write 1244
        op("R4", 16'h12F0, 8'h20, 1);   // dummy 1210 then write 1310
        op("R5", 16'hFFF0, 8'h20, 0);   // dummy FF10 then 0010
        op("R5", 16'hFFFF, 8'hFF, 1);   // dummy FFFE then write 00FE

        // R6: stretch both the dummy and the real cycle
        stag = "R6";
        step(1, 16'h05C0, 8'h60, 0, 1);
        step(0, 16'h0, 8'h0, 0, 0);
        step(0, 16'h0, 8'h0, 0, 0);
        step(0, 16'h0, 8'h0, 0, 1);
        step(0, 16'h0, 8'h0, 0, 0);
        step(0, 16'h0, 8'h0, 0, 1);
        idle(3);
        step(1, 16'h2210, 8'h01, 1, 0);
        step(0, 16'h0, 8'h0, 0, 0);
        step(0, 16'h0, 8'h0, 0, 1);
        step(0, 16'h0, 8'h0, 0, 0);
        step(0, 16'h0, 8'h0, 0, 1);
        idle(3);

        // R10: starts during a sequence, including with the final access
        stag = "R10";
        step(1, 16'h3090, 8'h90, 0, 1);
        step(1, 16'h7777, 8'h11, 1, 1);
        step(1, 16'h6666, 8'h22, 1, 1);
        idle(3);
        step(1, 16'h0100, 8'h05, 0, 0);
        step(1, 16'hABCD, 8'hEF, 1, 0);
        step(1, 16'hABCD, 8'hEF, 1, 1);
        idle(3);

        // R1: reset in the middle of a sequence
        stag = "R1";
        step(1, 16'h01FF, 8'h01, 1, 1);
        rst_n = 1'b0;
        step(0, 16'h0, 8'h0, 0, 1);
        rst_n = 1'b1;
        idle(3);
        check(eff_addr === 16'h0 && cyc_count === 2'd0, "R1", "state after reset",
              {eff_addr, 14'h0, cyc_count}, 0);

        // R9: final counts hold until the next start
        op("R9", 16'h0010, 8'h01, 0);
        check(cyc_count === 2'd1, "R9", "read count", cyc_count, 1);
        op("R9", 16'h0010, 8'h01, 1);
        check(cyc_count === 2'd2, "R9", "write count", cyc_count, 2);
        op("R9", 16'h00FF, 8'h01, 0);
        check(cyc_count === 2'd2, "R9", "crossing read count", cyc_count, 2);
        check(eff_addr === 16'h0100, "R8", "held eff_addr", eff_addr, 16'h0100);

        finish_run();
    end

endmodule